// File: doc/BRIEF.md
# Context-switch microcode sequencer

This block runs a short microprogram that steers the saving or restoring of a graphics engine's register context. Host software first fills a 256-word instruction store. It writes a start address to an index port, then streams 24-bit words to a data port, and the index advances by one after every word. A start pulse then sets the program counter to zero, and the sequencer executes one instruction per cycle until the program ends or an illegal word is found.

Transfer instructions place a register word index, a count and the current swap direction on a request bus. The bus holds these values until a downstream save/restore engine acknowledges. Other instructions do the following: load a 20-bit length used by bulk transfers, branch or stall on one of 128 flags, write a program-owned flag, or pulse a command code out to the engine. Some flags are inputs from the engine or are constants. The program cannot overwrite those.

Top module: `ctx_microseq`

## Requirements
- R1: A host write to the index port loads the store address from host_wdata[7:0]. Each data-port write stores host_wdata at that address and then increments the address. A later rewrite of a single word changes only that instruction.
- R2: After reset, running, done, error, xfer_req and cmd_valid are 0 and xfer_len is 0. A start pulse sets the program counter to 0, sets running to 1, and clears done and error.
- R3: A word with bits 23:20 = 1 is a transfer. It drives xfer_req with xfer_idx = bits 13:0, xfer_cnt = bits 19:14 and xfer_save = flag 0. These values stay stable until a cycle with xfer_ack high, and the program counter then advances.
- R4: A word with bits 23:20 = 2 loads xfer_len from bits 19:0. xfer_len changes only while a program runs.
- R5: A word with bits 23:20 = 4 is a branch to address bits 15:8 on flag bits 6:0. If bit 7 is 0 the branch is taken when the flag is 1. If bit 7 is 1 the branch is taken when the flag is 0. When the branch is not taken, execution goes to the next word.
- R6: A word with bits 23:20 = 5 stalls execution until the flag named in bits 6:0 equals bit 7.
- R7: A word with bits 23:20 = 7 writes bit 7 into the flag named in bits 6:0. Flag 0 is the swap direction: 0 means load, 1 means save.
- R8: Flag 96 reads the stat_busy input, flags 100 and 101 read auto_save_req and auto_load_req, and flag 104 always reads 1. Set-flag writes to these four flags have no effect.
- R9: The words 0x6000xx other than 0x60000e pulse cmd_valid for one cycle, with cmd_code equal to the low byte. The word 0x60000e ends the program: running goes low and done goes high. After that no request or command appears until the next start.
- R10: Any other word stops the sequencer and sets error. This includes 0x6 words whose bits 19:8 are not zero. error stays set until the next start, and done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_idx_we | input | 1 | Load store index from host_wdata |
| host_data_we | input | 1 | Write host_wdata to store, advance index |
| host_wdata | input | 24 | Host write data |
| start | input | 1 | Start program at address 0 |
| stat_busy | input | 1 | Engine busy status (flag 96) |
| auto_save_req | input | 1 | Automatic save pending (flag 100) |
| auto_load_req | input | 1 | Automatic load pending (flag 101) |
| xfer_ack | input | 1 | Downstream accepts the transfer |
| xfer_req | output | 1 | Transfer request valid |
| xfer_idx | output | 14 | First register word index |
| xfer_cnt | output | 6 | Number of registers |
| xfer_save | output | 1 | Direction: 1 save, 0 load |
| xfer_len | output | 20 | Bulk transfer length |
| cmd_valid | output | 1 | Command pulse |
| cmd_code | output | 8 | Command code |
| running | output | 1 | Program executing |
| done | output | 1 | Program ended normally |
| error | output | 1 | Stopped on an illegal word |

## Verification
The checker verifies on every cycle that an unacknowledged request holds its index, count and direction steady. It also verifies that requests appear only during a run and that done and error each exclude running. Further cycle checks cover error staying set, xfer_len changing only inside a run, and cmd_valid never carrying the end code. The following behaviours can be shown only by the bench's programs, with both directed and randomly generated transfer sequences:
- branch polarity and targets;
- stalls on external flags;
- writes to hard-wired flags being ignored;
- the exact fields of each transfer;
- rewriting a single store word.

// File: rtl/ctx_microseq.sv
module ctx_microseq #(
  parameter int DEPTH = 256,
  parameter int AW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_idx_we,
  input  logic        host_data_we,
  input  logic [23:0] host_wdata,
  input  logic        start,
  input  logic        stat_busy,
  input  logic        auto_save_req,
  input  logic        auto_load_req,
  input  logic        xfer_ack,
  output logic        xfer_req,
  output logic [13:0] xfer_idx,
  output logic [5:0]  xfer_cnt,
  output logic        xfer_save,
  output logic [19:0] xfer_len,
  output logic        cmd_valid,
  output logic [7:0]  cmd_code,
  output logic        running,
  output logic        done,
  output logic        error
);
  localparam int NFLAG = 128;

  logic [23:0]      store [DEPTH];
  logic [AW-1:0]    hidx, pc;
  logic [NFLAG-1:0] wflag;
  logic             fval;

  wire [23:0] ins  = store[pc];
  wire [3:0]  op   = ins[23:20];
  wire [6:0]  fsel = ins[6:0];
  wire        pol  = ins[7];

  wire is_ctx  = op == 4'h1;
  wire is_lsr  = op == 4'h2;
  wire is_bra  = op == 4'h4;
  wire is_wait = op == 4'h5;
  wire is_set  = op == 4'h7;
  wire is_misc = op == 4'h6 && ins[19:8] == 12'h000;
  wire is_end  = is_misc && ins[7:0] == 8'h0e;
  wire illegal = !(is_ctx || is_lsr || is_bra || is_wait || is_set || is_misc);
  wire hw_flag = fsel == 7'd96 || fsel == 7'd100 || fsel == 7'd101 || fsel == 7'd104;

  always_comb begin
    case (fsel)
      7'd96:   fval = stat_busy;
      7'd100:  fval = auto_save_req;
      7'd101:  fval = auto_load_req;
      7'd104:  fval = 1'b1;
      default: fval = wflag[fsel];
    endcase
  end

  assign xfer_req  = running && is_ctx;
  assign xfer_idx  = ins[13:0];
  assign xfer_cnt  = ins[19:14];
  assign xfer_save = wflag[0];
  assign cmd_valid = running && is_misc && !is_end;
  assign cmd_code  = ins[7:0];

  always_ff @(posedge clk) begin
    if (host_data_we) store[hidx] <= host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hidx     <= '0;
      pc       <= '0;
      wflag    <= '0;
      running  <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
      xfer_len <= '0;
    end else begin
      if (host_idx_we)       hidx <= host_wdata[AW-1:0];
      else if (host_data_we) hidx <= hidx + 1'b1;
      if (start) begin
        pc      <= '0;
        running <= 1'b1;
        done    <= 1'b0;
        error   <= 1'b0;
      end else if (running) begin
        if (illegal) begin
          running <= 1'b0;
          error   <= 1'b1;
        end else if (is_end) begin
          running <= 1'b0;
          done    <= 1'b1;
        end else if (is_ctx) begin
          if (xfer_ack) pc <= pc + 1'b1;
        end else if (is_wait) begin
          if (fval == pol) pc <= pc + 1'b1;
        end else if (is_bra) begin
          if (fval != pol) pc <= AW'(ins[15:8]);
          else             pc <= pc + 1'b1;
        end else begin
          if (is_lsr) xfer_len <= ins[19:0];
          if (is_set && !hw_flag) wflag[fsel] <= pol;
          pc <= pc + 1'b1;
        end
      end
    end
  end
endmodule

module ctx_microseq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        xfer_ack,
  input logic        xfer_req,
  input logic [13:0] xfer_idx,
  input logic [5:0]  xfer_cnt,
  input logic        xfer_save,
  input logic [19:0] xfer_len,
  input logic        cmd_valid,
  input logic [7:0]  cmd_code,
  input logic        running,
  input logic        done,
  input logic        error
);
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack && !start) |=> (xfer_req && $stable(xfer_idx) && $stable(xfer_cnt) && $stable(xfer_save)));
  assert_req_in_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> running);
  assert_len_in_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(xfer_len) |-> $past(running));
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!running && !xfer_req && !cmd_valid));
  assert_no_end_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_code != 8'h0e);
  assert_err_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!running && !done));
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error);
endmodule

bind ctx_microseq ctx_microseq_chk u_chk (.*);

// File: tb/ctx_microseq_test.sv
`timescale 1ns/1ps
module ctx_microseq_test;
  logic clk = 0, rst_n = 0;
  logic host_idx_we = 0, host_data_we = 0;
  logic [23:0] host_wdata = 0;
  logic start = 0, stat_busy = 0, auto_save_req = 0, auto_load_req = 0, xfer_ack = 0;
  logic xfer_req, xfer_save, cmd_valid, running, done, error;
  logic [13:0] xfer_idx;
  logic [5:0] xfer_cnt;
  logic [19:0] xfer_len;
  logic [7:0] cmd_code;

  ctx_microseq uut (.*);

  always #2 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0, stab_err = 0;
  int nreq = 0, ncmd = 0;
  int r_idx [64];
  int r_cnt [64];
  int r_dir [64];
  int c_log [64];
  logic [23:0] prog [64];
  int plen;
  int e_idx [8];
  int e_cnt [8];
  int e_dir [8];

  function automatic logic [23:0] w_ctx(int idx, int cnt);
    return 24'h100000 | 24'((cnt & 63) << 14) | 24'(idx & 16'h3fff);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_all();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // ack driver, request/command monitor, watchdog
  initial begin : mon
    int dly;
    bit hold;
    int h_idx, h_cnt, h_dir;
    dly = 0; hold = 0; h_idx = 0; h_cnt = 0; h_dir = 0;
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL R2 watchdog actual=%0d expected=%0d", cycles, 150000);
        finish_all();
      end
      if (cmd_valid && ncmd < 64) begin c_log[ncmd] = int'(cmd_code); ncmd++; end
      if (xfer_req) begin
        if (hold && (int'(xfer_idx) != h_idx || int'(xfer_cnt) != h_cnt || int'(xfer_save) != h_dir))
          stab_err++;
        if (dly == 0) begin
          xfer_ack = 1;
          if (nreq < 64) begin
            r_idx[nreq] = int'(xfer_idx); r_cnt[nreq] = int'(xfer_cnt); r_dir[nreq] = int'(xfer_save);
            nreq++;
          end
          hold = 0;
          dly = int'($urandom % 4);
        end else begin
          xfer_ack = 0;
          dly--;
          hold = 1;
          h_idx = int'(xfer_idx); h_cnt = int'(xfer_cnt); h_dir = int'(xfer_save);
        end
      end else begin
        xfer_ack = 0;
        if (hold) stab_err++;
        hold = 0;
      end
    end
  end

  task automatic load(int base);
    @(negedge clk);
    host_idx_we = 1; host_wdata = 24'(base);
    @(negedge clk);
    host_idx_we = 0;
    for (int i = 0; i < plen; i++) begin
      host_data_we = 1; host_wdata = prog[i];
      @(negedge clk);
    end
    host_data_we = 0;
  endtask

  task automatic kick();
    @(negedge clk);
    nreq = 0; ncmd = 0;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic run();
    int t;
    kick();
    t = 0;
    while (!done && !error && t < 3000) begin @(negedge clk); t++; end
  endtask

  initial begin : main
    int k, L;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    chk(!running && !done && !error, "R2 reset flags", {running, done, error}, 0);
    chk(!xfer_req && !cmd_valid, "R2 reset outputs", {xfer_req, cmd_valid}, 0);
    chk(xfer_len == 0, "R2 reset len", int'(xfer_len), 0);

    // Basic program: R4 R3 R7 R9 R1
    prog[0] = 24'h212345; prog[1] = 24'h700080; prog[2] = w_ctx(16'h0123, 5);
    prog[3] = 24'h600007; prog[4] = 24'h600009; prog[5] = 24'h60000e; plen = 6;
    load(0);
    kick();
    chk(running && !done, "R2 start runs", {running, done}, 2);
    while (!done && !error) @(negedge clk);
    chk(xfer_len == 20'h12345, "R4 length", int'(xfer_len), 32'h12345);
    chk(nreq == 1, "R3 request count", nreq, 1);
    chk(r_idx[0] == 16'h0123 && r_cnt[0] == 5, "R3 fields", r_idx[0] * 64 + r_cnt[0], 16'h0123 * 64 + 5);
    chk(r_dir[0] == 1, "R7 direction save", r_dir[0], 1);
    chk(ncmd == 2 && c_log[0] == 7 && c_log[1] == 9, "R9 command pulses", c_log[0] * 256 + c_log[1], 16'h0709);
    chk(done && !running && !error, "R9 end", {done, running, error}, 4);
    repeat (10) @(negedge clk);
    chk(nreq == 1 && ncmd == 2 && done, "R9 quiet after end", nreq + ncmd, 3);

    // R1 single word rewrite at index 2
    prog[0] = w_ctx(16'h3abc, 63); plen = 1;
    load(2);
    run();
    chk(nreq == 1 && r_idx[0] == 16'h3abc && r_cnt[0] == 63, "R1 rewrite", r_idx[0], 16'h3abc);

    // R5 R8 branches
    prog[0] = 24'h700087; prog[1] = 24'h400507; prog[2] = w_ctx(1, 1); prog[3] = w_ctx(2, 1);
    prog[4] = 24'h60000e; prog[5] = 24'h4008e8; prog[6] = w_ctx(16'h00aa, 1); prog[7] = 24'h400989;
    prog[8] = w_ctx(3, 1); prog[9] = 24'h60000e; plen = 10;
    load(0);
    run();
    chk(done && nreq == 1, "R5 branch path count", nreq, 1);
    chk(r_idx[0] == 16'h00aa, "R5 branch target", r_idx[0], 16'h00aa);

    // R8 hard-wired flags ignore writes
    auto_save_req = 0; stat_busy = 0;
    prog[0] = 24'h700068; prog[1] = 24'h7000e4; prog[2] = 24'h4006e8; prog[3] = 24'h400664;
    prog[4] = w_ctx(16'h00bb, 4); prog[5] = 24'h60000e; prog[6] = w_ctx(16'h00de, 1);
    prog[7] = 24'h60000e; plen = 8;
    load(0);
    run();
    chk(done && nreq == 1 && r_idx[0] == 16'h00bb, "R8 write ignored", r_idx[0], 16'h00bb);

    // R6 R8 waits on external flags
    stat_busy = 1; auto_save_req = 0;
    prog[0] = 24'h500060; prog[1] = w_ctx(16'h0055, 2); prog[2] = 24'h5000e4;
    prog[3] = w_ctx(16'h0066, 3); prog[4] = 24'h60000e; plen = 5;
    load(0);
    kick();
    repeat (20) @(negedge clk);
    chk(running && nreq == 0, "R6 stall on busy", nreq, 0);
    stat_busy = 0;
    repeat (20) @(negedge clk);
    chk(running && nreq == 1 && r_idx[0] == 16'h0055, "R6 release busy", nreq, 1);
    auto_save_req = 1;
    repeat (20) @(negedge clk);
    chk(done && nreq == 2 && r_idx[1] == 16'h0066, "R8 wait on auto save", nreq, 2);
    auto_save_req = 0;

    // R10 illegal words
    prog[0] = 24'h600007; prog[1] = 24'h300000; prog[2] = w_ctx(1, 1); prog[3] = 24'h60000e; plen = 4;
    load(0);
    run();
    repeat (5) @(negedge clk);
    chk(error && !done && !running, "R10 stop on illegal", {error, done, running}, 4);
    chk(nreq == 0 && ncmd == 1, "R10 nothing after illegal", nreq, 0);
    prog[0] = 24'h601007; plen = 1;
    load(0);
    run();
    chk(error && ncmd == 0, "R10 misc with bad bits", ncmd, 0);
    prog[0] = 24'h60000e; plen = 1;
    load(0);
    run();
    chk(!error && done, "R10 cleared by start", {error, done}, 1);

    // random transfer programs: R3 R4 R7
    for (int p = 0; p < 12; p++) begin
      k = 1 + int'($urandom % 4);
      plen = 0;
      for (int j = 0; j < k; j++) begin
        e_dir[j] = int'($urandom % 2);
        e_idx[j] = int'($urandom % 16384);
        e_cnt[j] = int'($urandom % 64);
        prog[plen] = 24'h700000 | 24'(e_dir[j] << 7); plen++;
        prog[plen] = w_ctx(e_idx[j], e_cnt[j]); plen++;
      end
      L = int'($urandom % (1 << 20));
      prog[plen] = 24'h200000 | 24'(L); plen++;
      prog[plen] = 24'h60000e; plen++;
      load(0);
      run();
      chk(done && nreq == k, "R3 random count", nreq, k);
      for (int j = 0; j < k; j++) begin
        chk(r_idx[j] == e_idx[j] && r_cnt[j] == e_cnt[j], "R3 random fields", r_idx[j], e_idx[j]);
        chk(r_dir[j] == e_dir[j], "R7 random direction", r_dir[j], e_dir[j]);
      end
      chk(int'(xfer_len) == L, "R4 random length", int'(xfer_len), L);
    end

    chk(stab_err == 0, "R3 request held until ack", stab_err, 0);
    finish_all();
  end
endmodule